// File: doc/BRIEF.md
# Two-wire debug port master

This block drives the debug port of a small 8051-class target over two wires plus a reset. It owns the debug clock, a single data pin that turns around between command and reply, and the active-low target reset. A host-side controller issues one request at a time. A request either runs the debug-entry pattern, runs the exit reset pulse, shifts a block of command bytes out, or shifts command bytes out and then reads back one reply byte. A transfer never sends and receives at once.

All pin timing is built from a half-period counted in system clocks. The value is taken from `half_period` when a request is accepted, and it keeps the debug clock under the target's limit of about 30 MHz. While the block is idle, the clock, data and reset pins sit high and the data pin is driven. A one-cycle `done` pulse ends each request. On a read request, the reply byte appears on `rx_byte` in that same cycle.

Top module: `dbg2w_master`

## Requirements
- R1: After reset, and in every cycle with `busy` low, `dbg_clk`, `dbg_rst_n`, `dbg_dat_o` and `dbg_dat_oe` are all 1, and `done` is 0 right after reset.
- R2: A request is taken when `req_valid` is 1 and `busy` is 0, and `busy` is 1 from the next cycle. A `req_valid` seen while `busy` is 1 is ignored and starts no further request.
- R3: Each half-phase lasts HP system clocks, where HP is `half_period` captured at acceptance and a value of 0 counts as 1. Changing `half_period` during a request has no effect on that request.
- R4: Op code 2'b01 (write) sends N bytes, where N is `req_len` clamped to MAX_BYTES. Byte j is `req_data[8j+7:8j]` and goes out in order j = 0 upward, most significant bit first. Each bit spans a low half then a high half of `dbg_clk`. The data bit changes only as the clock falls. One further half with the clock low and data 1 follows, so the request takes 16N+1 halves.
- R5: Op code 2'b10 (write-read) sends N bytes as in R4 and then one reply byte with `dbg_dat_oe` at 0 and `dbg_dat_o` at 1. `dbg_dat_i` is sampled as each high half ends (the falling edge) and assembled MSB first. The request ends with a low tail half that keeps `dbg_dat_oe` at 0, taking 16(N+1)+1 halves in total.
- R6: Op code 2'b00 (debug entry) holds `dbg_rst_n` low for 5 halves with `dbg_clk` at 1,0,1,0,1. This gives two rising clock edges while reset is low, after which reset is released with the clock high.
- R7: Op code 2'b11 (debug exit) holds `dbg_rst_n` low for 2 halves with `dbg_clk` held at 1, so no clock pulses occur.
- R8: `done` pulses for exactly one cycle, in the cycle `busy` falls. `rx_byte` takes the reply on a write-read request and keeps its value after any other request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_period | input | DIV_W | Half-period of the debug clock in system clocks |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 entry, 01 write, 10 write-read, 11 exit |
| req_len | input | LEN_W | Number of command bytes |
| req_data | input | 8*MAX_BYTES | Command bytes, byte 0 in the low bits |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Last reply byte |
| dbg_clk | output | 1 | Debug clock |
| dbg_rst_n | output | 1 | Target reset, active low |
| dbg_dat_o | output | 1 | Data pin output value |
| dbg_dat_oe | output | 1 | Data pin output enable |
| dbg_dat_i | input | 1 | Data pin input value |

## Verification
A request is accepted on the rising edge at which `req_valid` is seen. The pin levels of half h are visible from h*HP edges after that edge, and `done`, the idle levels and a new `rx_byte` all appear at HALVES*HP edges. The bench counts cycles from acceptance at every falling edge and compares all four pins against the half index it works out itself. It changes `dbg_dat_i` in the same falling-edge slot, so the reply bit is in place at the edge that ends each high half. One cycle after `done`, it checks that `done` has dropped and that no second request has started.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;

  typedef enum logic [1:0] {
    OP_ENTER = 2'b00,
    OP_WRITE = 2'b01,
    OP_XFER  = 2'b10,
    OP_EXIT  = 2'b11
  } dbg_op_e;

  typedef struct packed {
    logic clk;
    logic rst_n;
    logic oe;
    logic dat;
  } pins_t;

  localparam pins_t PINS_IDLE = '{clk: 1'b1, rst_n: 1'b1, oe: 1'b1, dat: 1'b1};

  localparam int ENTER_HALVES = 5;
  localparam int EXIT_HALVES  = 2;
  localparam int BIT_HALVES   = 2;
  localparam int BYTE_HALVES  = 16;

endpackage

// File: rtl/dbg2w_tick.sv
module dbg2w_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] hp,
  output logic             half_end
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim_q;

  assign half_end = run && (cnt_q == lim_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= DIV_W'(1);
    end else if (start) begin
      cnt_q <= '0;
      lim_q <= (hp == '0) ? DIV_W'(1) : hp;
    end else if (run) begin
      cnt_q <= half_end ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/dbg2w_rxshift.sv
module dbg2w_rxshift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {q[W-2:0], bit_in};
  end

endmodule

// File: rtl/dbg2w_master.sv
module dbg2w_master
  import dbg2w_pkg::*;
#(
  parameter  int MAX_BYTES = 4,
  parameter  int DIV_W     = 8,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int DATA_W    = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rx_byte,
  output logic              dbg_clk,
  output logic              dbg_rst_n,
  output logic              dbg_dat_o,
  output logic              dbg_dat_oe,
  input  logic              dbg_dat_i
);

  localparam int MAX_HALVES = BYTE_HALVES * (MAX_BYTES + 1) + 1;
  localparam int IDX_W      = $clog2(MAX_HALVES + 1);

  logic [1:0]        op_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_q;
  pins_t             pins_q;
  logic              start;
  logic              half_end;
  logic              rx_shift;
  logic [7:0]        rx_q;
  logic [LEN_W-1:0]  len_eff;

  function automatic pins_t pins_for(input logic [1:0] op, input logic [LEN_W-1:0] n,
                                     input logic [DATA_W-1:0] d, input logic [IDX_W-1:0] h);
    pins_t p;
    int    nb, k, b, pos;
    p = PINS_IDLE;
    case (dbg_op_e'(op))
      OP_ENTER: begin
        p.rst_n = 1'b0;
        p.clk   = ~h[0];
      end
      OP_EXIT: p.rst_n = 1'b0;
      default: begin
        nb = int'(n) + ((dbg_op_e'(op) == OP_XFER) ? 1 : 0);
        k  = int'(h) / BYTE_HALVES;
        b  = (int'(h) / BIT_HALVES) % 8;
        if (int'(h) == BYTE_HALVES * nb) begin
          p.clk = 1'b0;
          p.oe  = (dbg_op_e'(op) != OP_XFER);
        end else begin
          p.clk = h[0];
          if (dbg_op_e'(op) == OP_XFER && k == int'(n)) begin
            p.oe = 1'b0;
          end else begin
            pos   = k * 8 + 7 - b;
            p.dat = (pos < DATA_W) ? d[pos] : 1'b1;
          end
        end
      end
    endcase
    return p;
  endfunction

  function automatic logic [IDX_W-1:0] last_for(input logic [1:0] op, input logic [LEN_W-1:0] n);
    int tot;
    case (dbg_op_e'(op))
      OP_ENTER: tot = ENTER_HALVES;
      OP_EXIT:  tot = EXIT_HALVES;
      OP_XFER:  tot = BYTE_HALVES * (int'(n) + 1) + 1;
      default:  tot = BYTE_HALVES * int'(n) + 1;
    endcase
    return IDX_W'(tot - 1);
  endfunction

  assign start   = req_valid && !busy;
  assign len_eff = (int'(req_len) > MAX_BYTES) ? LEN_W'(MAX_BYTES) : req_len;

  assign rx_shift = busy && half_end && (dbg_op_e'(op_q) == OP_XFER) && idx_q[0] &&
                    (int'(idx_q) / BYTE_HALVES == int'(len_q));

  dbg2w_tick #(.DIV_W(DIV_W)) i_tick (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .run      (busy),
    .hp       (half_period),
    .half_end (half_end)
  );

  dbg2w_rxshift #(.W(8)) i_rx (
    .clk      (clk),
    .rst      (rst),
    .shift_en (rx_shift),
    .bit_in   (dbg_dat_i),
    .q        (rx_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
      op_q    <= '0;
      len_q   <= '0;
      data_q  <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      pins_q  <= PINS_IDLE;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        op_q   <= req_op;
        len_q  <= len_eff;
        data_q <= req_data;
        idx_q  <= '0;
        last_q <= last_for(req_op, len_eff);
        pins_q <= pins_for(req_op, len_eff, req_data, '0);
      end else if (busy && half_end) begin
        if (idx_q == last_q) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          pins_q <= PINS_IDLE;
          if (dbg_op_e'(op_q) == OP_XFER) rx_byte <= rx_q;
        end else begin
          idx_q  <= idx_q + 1'b1;
          pins_q <= pins_for(op_q, len_q, data_q, idx_q + 1'b1);
        end
      end
    end
  end

  assign dbg_clk    = pins_q.clk;
  assign dbg_rst_n  = pins_q.rst_n;
  assign dbg_dat_o  = pins_q.dat;
  assign dbg_dat_oe = pins_q.oe;

endmodule

// File: rtl/dbg2w_master_chk.sv
module dbg2w_master_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic dbg_clk,
  input logic dbg_rst_n,
  input logic dbg_dat_o,
  input logic dbg_dat_oe
);

  a_r1_idle_pins_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (dbg_clk && dbg_rst_n && dbg_dat_o && dbg_dat_oe));

  a_r2_busy_needs_request: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  a_r4_data_steady_clk_high: assert property (@(posedge clk) disable iff (rst)
    (dbg_clk && $past(dbg_clk) && dbg_dat_oe && $past(dbg_dat_oe)) |-> $stable(dbg_dat_o));

  a_r5_release_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(dbg_dat_oe) |-> !dbg_clk);

  a_r6_reset_only_when_busy: assert property (@(posedge clk) disable iff (rst)
    !dbg_rst_n |-> busy);

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

endmodule

bind dbg2w_master dbg2w_master_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .busy       (busy),
  .done       (done),
  .dbg_clk    (dbg_clk),
  .dbg_rst_n  (dbg_rst_n),
  .dbg_dat_o  (dbg_dat_o),
  .dbg_dat_oe (dbg_dat_oe)
);

// File: tb/test_dbg2w_master.sv
module test_dbg2w_master;

  localparam int MAXB  = 4;
  localparam int DIVW  = 8;
  localparam int LW    = $clog2(MAXB + 1);
  localparam int DATW  = 8 * MAXB;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [DIVW-1:0] half_period = 8'd1;
  logic            req_valid = 1'b0;
  logic [1:0]      req_op = 2'b00;
  logic [LW-1:0]   req_len = '0;
  logic [DATW-1:0] req_data = '0;
  logic            busy, done, dbg_clk, dbg_rst_n, dbg_dat_o, dbg_dat_oe;
  logic [7:0]      rx_byte;
  logic            dbg_dat_i = 1'b0;

  int   n_tests = 0;
  int   n_fail  = 0;
  logic [7:0] prev_rx = 8'h00;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  dbg2w_master #(.MAX_BYTES(MAXB), .DIV_W(DIVW)) i_dbg2w_master (
    .clk(clk), .rst(rst), .half_period(half_period), .req_valid(req_valid),
    .req_op(req_op), .req_len(req_len), .req_data(req_data), .busy(busy),
    .done(done), .rx_byte(rx_byte), .dbg_clk(dbg_clk), .dbg_rst_n(dbg_rst_n),
    .dbg_dat_o(dbg_dat_o), .dbg_dat_oe(dbg_dat_oe), .dbg_dat_i(dbg_dat_i)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int total_halves(input int op, input int n);
    if (op == 0) return 5;
    if (op == 3) return 2;
    if (op == 2) return 16 * (n + 1) + 1;
    return 16 * n + 1;
  endfunction

  // {clk, rst_n, oe, dat}
  function automatic logic [3:0] exp_pins(input int op, input int n, input logic [DATW-1:0] d, input int h);
    int nb, k, b;
    if (op == 0) return {((h % 2) == 0), 1'b0, 1'b1, 1'b1};
    if (op == 3) return 4'b1011;
    nb = n + ((op == 2) ? 1 : 0);
    if (h == 16 * nb) return {1'b0, 1'b1, (op != 2), 1'b1};
    k = h / 16;
    b = (h / 2) % 8;
    if (op == 2 && k == n) return {(h % 2) == 1, 1'b1, 1'b0, 1'b1};
    return {(h % 2) == 1, 1'b1, 1'b1, d[k * 8 + 7 - b]};
  endfunction

  task automatic run_txn(input int op, input int len, input logic [DATW-1:0] data,
                         input int hp, input logic [7:0] reply, input bit poke);
    int hpe, n, tot, h;
    logic [3:0] act, exp;
    bit wave_ok, busy_ok;
    logic [3:0] bad_act, bad_exp;
    string tag;
    hpe = (hp == 0) ? 1 : hp;
    n   = (len > MAXB) ? MAXB : len;
    tot = total_halves(op, n);
    tag = (op == 0) ? "R6 entry" : (op == 3) ? "R7 exit" : (op == 1) ? "R4 write (R3 timing)" : "R5 write-read (R3 timing)";
    wave_ok = 1'b1; busy_ok = 1'b1; bad_act = '0; bad_exp = '0;
    @(negedge clk);
    half_period = DIVW'(hp);
    req_op = 2'(op); req_len = LW'(len); req_data = data; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c <= tot * hpe; c++) begin
      if (c > 0) @(negedge clk);
      h = c / hpe;
      if (op == 2 && h / 16 == n && h < 16 * (n + 1)) dbg_dat_i = reply[7 - (h / 2) % 8];
      else dbg_dat_i = 1'b0;
      if (poke && c == 3) begin
        half_period = DIVW'(hpe + 2);
        req_op = 2'b00; req_valid = 1'b1;
      end
      if (poke && c == 4) req_valid = 1'b0;
      if (c < tot * hpe) begin
        act = {dbg_clk, dbg_rst_n, dbg_dat_oe, dbg_dat_o};
        exp = exp_pins(op, n, data, h);
        if (act !== exp && wave_ok) begin wave_ok = 1'b0; bad_act = act; bad_exp = exp; end
        if (busy !== 1'b1 || done !== 1'b0) busy_ok = 1'b0;
      end
    end
    check(wave_ok, tag, 32'(bad_act), 32'(bad_exp));
    check(busy_ok, "R2 busy held through request", 32'(busy), 32'd1);
    check(done === 1'b1 && busy === 1'b0 &&
          {dbg_clk, dbg_rst_n, dbg_dat_oe, dbg_dat_o} === 4'b1111,
          "R8 done at end with R1 idle pins", {27'd0, done, dbg_clk, dbg_rst_n, dbg_dat_oe, dbg_dat_o}, 32'h1f);
    if (op == 2) prev_rx = reply;
    check(rx_byte === prev_rx, (op == 2) ? "R5 reply byte" : "R8 rx_byte kept", 32'(rx_byte), 32'(prev_rx));
    half_period = DIVW'(hp);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R2 R8 single done, ignored request", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd8051);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 &&
          {dbg_clk, dbg_rst_n, dbg_dat_oe, dbg_dat_o} === 4'b1111,
          "R1 reset state", {26'd0, busy, done, dbg_clk, dbg_rst_n, dbg_dat_oe, dbg_dat_o}, 32'h0f);

    run_txn(0, 0, '0, 2, 8'h00, 1'b0);
    run_txn(1, 1, 32'h0000_00A5, 1, 8'h00, 1'b0);
    run_txn(1, 4, 32'hDEAD_BEEF, 0, 8'h00, 1'b0);
    run_txn(2, 1, 32'h0000_0024, 2, 8'h3C, 1'b0);
    run_txn(2, 0, 32'h0, 1, 8'h81, 1'b0);
    run_txn(3, 0, '0, 3, 8'h00, 1'b0);
    run_txn(1, 6, 32'h1234_5678, 1, 8'h00, 1'b0);
    run_txn(2, 3, 32'h00C0_FFEE, 3, 8'h5A, 1'b1);
    run_txn(1, 2, 32'h0000_F00D, 5, 8'h00, 1'b1);
    run_txn(2, 4, 32'h89AB_CDEF, 1, 8'hFF, 1'b0);

    for (int i = 0; i < 24; i++) begin
      run_txn(int'($urandom % 4), int'($urandom % (MAXB + 1)), DATW'($urandom),
              int'($urandom % 4), 8'($urandom), 1'($urandom % 2));
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule